// File: doc/BRIEF.md
# Cascadable Low-Frequency Wakeup Timer

This block is a bank of three wakeup timers that advance on a slow oscillator tick of about 32 kHz. The tick reaches the block as a one-cycle enable in the system clock domain. Two 16-bit counters each repeat over a programmable number of ticks. The first of them can be chained into the second, so that the second counter advances once per interval of the first. A pair chained this way gives very long wakeup intervals with single-tick granularity. For example, interval values of 3200 and 36000 give one event every 115,200,000 ticks, which is one hour at 32 kHz.

The third counter is a free-running 32-bit counter. Its event marks each change of one selected count bit, so its interval is always a power of two.

Each counter sets its own sticky status flag. The flag drives an interrupt output when the matching interrupt enable is set. Firmware uses the write port to set up the block. It can also retune the interval values while the counters run, to make up for oscillator drift.

Top module: `lf_wake_timer`

## Requirements
- R1: After reset, all three counts read 0, every status flag and interrupt output is 0, all counters are disabled and chaining is off.
- R2: An enabled 16-bit counter whose interval value is N counts 0, 1, …, N-1 on successive ticks. On the tick that finds it at N-1 it produces a one-tick event, sets its status flag and returns to 0, so events are N ticks apart. The value 0 means 65536 ticks.
- R3: With chaining on (write address 0, bit 3), counter 1 advances only on counter 0's events. Counter 1's event therefore comes once every N0·N1 ticks, and counter 0 keeps raising its own flag.
- R4: With chaining off, counters 0 and 1 both advance on every tick and count independently.
- R5: An interval value written while a counter is enabled first takes effect when the counter next returns to 0. The interval in progress runs to its old length. A disabled counter adopts a written value at once.
- R6: The 32-bit counter advances on every tick. Its event fires whenever count bit k changes, where k is bits [4:0] written to address 3, so events come every 2^k ticks. The first event comes 2^k ticks after enable.
- R7: Status flags (bit i for counter i) stay set until a write to address 4 with a 1 in bit i clears them. Zero bits in that write leave flags alone. An event in the same cycle as a clear leaves the flag set.
- R8: Interrupt output i equals status flag i gated by its interrupt-enable bit, which is bit 4+i at address 0.
- R9: A counter whose enable bit (bit i at address 0) is 0 holds count 0 and produces no events. Address 1 sets counter 0's interval and address 2 sets counter 1's, both from bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lf_tick | input | 1 | One-cycle pulse per low-frequency oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| irq | output | 3 | Interrupt per counter (bit i for counter i) |
| status | output | 3 | Sticky event flags per counter |
| count0 | output | 16 | Current count of counter 0 |
| count1 | output | 16 | Current count of counter 1 |
| count2 | output | 32 | Current count of the 32-bit counter |

## Verification
Every cycle, the assertions check several local properties:
- a counter returns to 0 after its event and never runs past its terminal value;
- a disabled counter sits at 0;
- the active interval of an enabled counter changes only at a wrap;
- a chained counter 1 holds still between counter 0 events;
- an event sets its flag, and flags hold when nothing clears them;
- a masked interrupt stays low.

Only the bench scenarios can show the event spacing under each configuration. These cover sweeps of interval values, the product interval of a chained pair, the old-then-new interval sequence after a mid-count rewrite, each power-of-two tap, and the set-beats-clear ordering.

// File: rtl/lfwt_pkg.sv
package lfwt_pkg;
  localparam int ADDR_W = 3;
  localparam int NCTR   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_TAP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

  // Control word layout: ie[6:4], chain[3], en[2:0]
  typedef struct packed {
    logic [NCTR-1:0] ie;
    logic            chain;
    logic [NCTR-1:0] en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lfwt_regs.sv
module lfwt_regs
  import lfwt_pkg::*;
#(
  parameter int CW    = 16,
  parameter int TAP_W = 5,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     per0,
  output logic [CW-1:0]     per1,
  output logic [TAP_W-1:0]  tap,
  output logic [NCTR-1:0]   clr
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [CW-1:0]     per0_q, per0_d, per1_q, per1_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DW-1:CW];

  always_comb begin
    ctrl_d = ctrl_q;
    per0_d = per0_q;
    per1_d = per1_q;
    tap_d  = tap_q;
    clr    = '0;
    if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:  ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        A_PER0:  per0_d = wr_data[CW-1:0];
        A_PER1:  per1_d = wr_data[CW-1:0];
        A_TAP:   tap_d  = wr_data[TAP_W-1:0];
        A_CLR:   clr    = wr_data[NCTR-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per0_q <= '0;
      per1_q <= '0;
      tap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per0_q <= per0_d;
      per1_q <= per1_d;
      tap_q  <= tap_d;
    end
  end

  assign ctrl = ctrl_q;
  assign per0 = per0_q;
  assign per1 = per1_q;
  assign tap  = tap_q;

  // R1: control holds its reset state until a control write occurs
  assert_ctrl_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/lfwt_match_ctr.sv
module lfwt_match_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic [CW-1:0] per_in,
  output logic [CW-1:0] cnt,
  output logic          match
);
  logic [CW-1:0] cnt_q, cnt_d, act_q, act_d, term;

  always_comb begin
    term  = act_q - 1'b1;
    match = en && adv && (cnt_q == term);
    if (!en)       cnt_d = '0;
    else if (match) cnt_d = '0;
    else if (adv)   cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
    act_d = (!en || match) ? per_in : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt = cnt_q;

  // R2: after an event the count restarts at zero
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));
  // R2: an enabled counter never runs past its terminal value
  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= term));
  // R5: active interval of a running counter changes only at a wrap
  assert_act_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !match) |=> $stable(act_q));
  // R9: disabled counter sits at zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/lfwt_tap_ctr.sv
module lfwt_tap_ctr #(
  parameter int FW    = 32,
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic [TAP_W-1:0] tap,
  output logic [FW-1:0]    cnt,
  output logic             evt
);
  logic [FW-1:0] cnt_q, cnt_d, nxt;

  always_comb begin
    nxt   = cnt_q + 1'b1;
    evt   = en && adv && (cnt_q[tap] != nxt[tap]);
    if (!en)      cnt_d = '0;
    else if (adv) cnt_d = nxt;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R6: events only on ticks of an enabled counter
  assert_evt_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (en && adv));
  // R6: no tick, no movement
  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/lfwt_flags.sv
module lfwt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  logic [N-1:0] flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign irq[i] = flag_q[i] & ie[i];

    // R7: an event always leaves its flag set, clear or not
    assert_set_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
    // R7: a set flag persists without a clear
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
    // R8: masked lane never interrupts
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ie[i] |-> !irq[i]);
  end
endmodule

// File: rtl/lf_wake_timer.sv
module lf_wake_timer
  import lfwt_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCTR-1:0]   irq,
  output logic [NCTR-1:0]   status,
  output logic [CW-1:0]     count0,
  output logic [CW-1:0]     count1,
  output logic [FW-1:0]     count2
);
  localparam int TAP_W = $clog2(FW);

  logic [1:0]       rs_q;
  logic             rst_i;
  ctrl_t            ctrl;
  logic [CW-1:0]    per0, per1;
  logic [TAP_W-1:0] tap;
  logic [NCTR-1:0]  clr, evt;
  logic             adv0, adv1, adv2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  lfwt_regs #(.CW(CW), .TAP_W(TAP_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .per0(per0), .per1(per1),
    .tap(tap), .clr(clr)
  );

  always_comb begin
    adv0 = lf_tick;
    adv1 = ctrl.chain ? evt[0] : lf_tick;
    adv2 = lf_tick;
  end

  lfwt_match_ctr #(.CW(CW)) u_ctr0 (
    .clk(clk), .rst_n(rst_i), .en(ctrl.en[0]), .adv(adv0),
    .per_in(per0), .cnt(count0), .match(evt[0])
  );

  lfwt_match_ctr #(.CW(CW)) u_ctr1 (
    .clk(clk), .rst_n(rst_i), .en(ctrl.en[1]), .adv(adv1),
    .per_in(per1), .cnt(count1), .match(evt[1])
  );

  lfwt_tap_ctr #(.FW(FW), .TAP_W(TAP_W)) u_ctr2 (
    .clk(clk), .rst_n(rst_i), .en(ctrl.en[2]), .adv(adv2),
    .tap(tap), .cnt(count2), .evt(evt[2])
  );

  lfwt_flags #(.N(NCTR)) u_flags (
    .clk(clk), .rst_n(rst_i), .set(evt), .clr(clr), .ie(ctrl.ie),
    .flag(status), .irq(irq)
  );

  // R3: a chained counter 1 moves only on counter 0 events
  assert_chain_gate_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl.chain && ctrl.en[1] && !evt[0]) |=> $stable(count1));
  // R4: unchained counters both step on a tick
  assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (!ctrl.chain && ctrl.en[1] && lf_tick && !evt[1]) |=> (count1 == $past(count1) + 1'b1));
endmodule

// File: tb/tb_lf_wake_timer.sv
module tb_lf_wake_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lf_tick;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  irq, status;
  logic [15:0] count0, count1;
  logic [31:0] count2;

  int n_cmp = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  lf_wake_timer dut (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .status(status),
    .count0(count0), .count1(count1), .count2(count2)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      lf_tick = 1'b1;
      repeat (n) @(negedge clk);
      lf_tick = 1'b0;
    end
  endtask

  // control word: ie[6:4], chain[3], en[2:0]
  function automatic logic [31:0] cw(input logic [2:0] en, input logic ch,
                                     input logic [2:0] ie);
    return {25'd0, ie, ch, en};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; lf_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state; ticks with nothing enabled change nothing (R9)
    chk("R1", "count0", 32'(count0), 0);
    chk("R1", "count1", 32'(count1), 0);
    chk("R1", "count2", count2, 0);
    chk("R1", "status", 32'(status), 0);
    chk("R1", "irq", 32'(irq), 0);
    ticks(10);
    chk("R9", "idle counts", 32'(count0) + 32'(count1) + count2, 0);
    chk("R9", "idle status", 32'(status), 0);

    // R2 sweep of counter 0 intervals
    for (int p = 1; p <= 7; p++) begin
      wr(3'd0, 0); wr(3'd1, 32'(p)); wr(3'd4, 7);
      wr(3'd0, cw(3'b001, 1'b0, 3'b001));
      ticks(p - 1);
      chk("R2", "count0 before wrap", 32'(count0), 32'(p - 1));
      chk("R2", "flag0 before wrap", 32'(status[0]), 0);
      ticks(1);
      chk("R2", "count0 after wrap", 32'(count0), 0);
      chk("R2", "flag0 at wrap", 32'(status[0]), 1);
      chk("R8", "irq0 enabled", 32'(irq[0]), 1);
    end

    // R4 independent counting
    wr(3'd0, 0); wr(3'd1, 3); wr(3'd2, 5); wr(3'd4, 7);
    wr(3'd0, cw(3'b011, 1'b0, 3'b000));
    ticks(7);
    chk("R4", "count0", 32'(count0), 1);
    chk("R4", "count1", 32'(count1), 2);
    chk("R4", "flags", 32'(status[1:0]), 2'b11);
    chk("R8", "irq masked", 32'(irq), 0);

    // R3 chained pair sweep
    for (int a = 2; a <= 3; a++) begin
      for (int b = 2; b <= 4; b++) begin
        wr(3'd0, 0); wr(3'd1, 32'(a)); wr(3'd2, 32'(b)); wr(3'd4, 7);
        wr(3'd0, cw(3'b011, 1'b1, 3'b010));
        ticks(a * b - 1);
        chk("R3", "count1 before", 32'(count1), 32'(b - 1));
        chk("R3", "count0 before", 32'(count0), 32'(a - 1));
        chk("R3", "flag1 before", 32'(status[1]), 0);
        chk("R3", "flag0 own", 32'(status[0]), 1);
        ticks(1);
        chk("R3", "flag1 at product", 32'(status[1]), 1);
        chk("R3", "irq1", 32'(irq[1]), 1);
        chk("R3", "count1 wrap", 32'(count1), 0);
      end
    end

    // R5 mid-count rewrite
    wr(3'd0, 0); wr(3'd1, 5); wr(3'd4, 7);
    wr(3'd0, cw(3'b001, 1'b0, 3'b000));
    ticks(2);
    wr(3'd1, 3);
    ticks(2);
    chk("R5", "old interval runs on", 32'(count0), 4);
    chk("R5", "no early event", 32'(status[0]), 0);
    ticks(1);
    chk("R5", "old interval ends", 32'(status[0]), 1);
    wr(3'd4, 1);
    ticks(2);
    chk("R5", "new interval count", 32'(count0), 2);
    chk("R5", "new interval no event", 32'(status[0]), 0);
    ticks(1);
    chk("R5", "new interval event", 32'(status[0]), 1);

    // R6 tap sweep
    for (int t = 0; t <= 5; t++) begin
      wr(3'd0, 0); wr(3'd3, 32'(t)); wr(3'd4, 7);
      wr(3'd0, cw(3'b100, 1'b0, 3'b100));
      ticks((1 << t) - 1);
      chk("R6", "count2 before", count2, 32'((1 << t) - 1));
      chk("R6", "flag2 before", 32'(status[2]), 0);
      ticks(1);
      chk("R6", "flag2 at 2^k", 32'(status[2]), 1);
      chk("R6", "irq2", 32'(irq[2]), 1);
      wr(3'd4, 4);
      ticks(1 << t);
      chk("R6", "second event", 32'(status[2]), 1);
    end

    // R7 / R8 flag behaviour
    wr(3'd0, 0); wr(3'd1, 1); wr(3'd4, 7);
    wr(3'd0, cw(3'b001, 1'b0, 3'b000));
    ticks(1);
    chk("R8", "flag0 masked set", 32'(status[0]), 1);
    chk("R8", "irq0 masked", 32'(irq[0]), 0);
    wr(3'd0, cw(3'b001, 1'b0, 3'b001));
    chk("R8", "irq0 unmasked", 32'(irq[0]), 1);
    lf_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 1;
    @(negedge clk);
    lf_tick = 1'b0; wr_en = 1'b0;
    chk("R7", "set beats clear", 32'(status[0]), 1);
    wr(3'd4, 2);
    chk("R7", "other bit clear ignored", 32'(status[0]), 1);
    wr(3'd4, 1);
    chk("R7", "w1c clears", 32'(status[0]), 0);
    chk("R7", "irq drops", 32'(irq[0]), 0);

    // R9 disabled counter after use
    wr(3'd0, 0); wr(3'd4, 7);
    ticks(6);
    chk("R9", "disabled counts", 32'(count0) + 32'(count1) + count2, 0);
    chk("R9", "disabled flags", 32'(status), 0);

    summary();
    $finish;
  end
endmodule